// File: doc/BRIEF.md
# Programmable Baud Rate Generator Bank

This block holds a set of independent baud rate generators, four by default. Each generator divides the block clock by a programmable ratio and emits a single-cycle clock enable. That enable is meant to be used as a 16x oversampling strobe by a serial transmitter or receiver. To get a bit rate B from a reference frequency F, software programs a divisor of F/(16·B) − 1.

A generator has a 12-bit down-counter. For very slow rates, an optional divide-by-16 stage can be placed in front of that counter, for ratios that do not fit in 12 bits. Each generator has its own 32-bit control word. The control word is written through a simple select/data port and read back through a registered read port. Routing the strobes to serial channels is done outside this block.

Top module: `baud_gen_bank`

## Requirements
- R1: After reset every control word reads 0x0000_0000 and every tick output is low.
- R2: Control word layout: bit 0 is the prescale enable, bits 12:1 hold the divisor N (ratio minus one), bit 16 is the generator enable, and all other bits read as zero. Read data appears one clock after rd_sel is presented.
- R3: When a disabled generator is enabled with prescale off, its first tick appears on the (N+2)th rising edge after the edge that captures the write.
- R4: With prescale off, ticks repeat every N+1 clocks. With N = 0 the tick is high on every clock.
- R5: With prescale on, ticks repeat every 16·(N+1) clocks, and the first tick after enabling comes 16·(N+1)+1 edges after the write edge.
- R6: A tick is a single-cycle pulse whenever the period is longer than one clock.
- R7: While a generator is disabled, its tick stays low and its counter is held. Re-enabling therefore restarts with the R3 latency.
- R8: A divisor written while the generator runs does not change the period in progress. It takes effect from the next reload.
- R9: Generators are independent. Writing or running one does not change the timing of another.
- R10: The largest divisor, 4095, gives a period of 4096 clocks with prescale off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the division reference |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for a control word |
| wr_sel | input | 2 | Generator index for the write |
| wr_data | input | 32 | Control word to write |
| rd_sel | input | 2 | Generator index for read-back |
| rd_data | output | 32 | Registered control word of the selected generator |
| tick | output | 4 | One 16x oversampling strobe per generator |

## Verification
Divisors of 0, small values, a mid value and 4095 are applied. These separate an off-by-one in the reload from a correct N+1 period, and they catch a counter that wraps wrongly at its full width. The prescaled case separates a divide-by-16 stage placed in front of the counter from one that is missing or mis-sized. The startup latency is measured from the write, both from the disabled state and after a stop, so that a counter left running while disabled is caught. A mid-period retune shows whether a new divisor cuts short the period in progress. Two generators running together show whether writes leak across.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int CTRL_W     = 32;
  localparam int DIV_W      = 12;
  localparam int DIV_LSB    = 1;
  localparam int PRE_BIT    = 0;
  localparam int EN_BIT     = 16;
  localparam int PRE_RATIO  = 16;

  typedef struct packed {
    logic             en;
    logic             pre;
    logic [DIV_W-1:0] div;
  } gen_ctrl_t;

  function automatic gen_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] w);
    gen_ctrl_t c;
    c.en  = w[EN_BIT];
    c.pre = w[PRE_BIT];
    c.div = w[DIV_LSB +: DIV_W];
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] pack_ctrl(input gen_ctrl_t c);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[EN_BIT]            = c.en;
    w[PRE_BIT]           = c.pre;
    w[DIV_LSB +: DIV_W]  = c.div;
    return w;
  endfunction
endpackage

// File: rtl/baud_ctrl_regs.sv
module baud_ctrl_regs
  import baud_pkg::*;
#(
  parameter int NUM_GEN = 4,
  localparam int SEL_W = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [CTRL_W-1:0]         wr_data,
  input  logic [SEL_W-1:0]          rd_sel,
  output logic [CTRL_W-1:0]         rd_data,
  output gen_ctrl_t [NUM_GEN-1:0]   ctrl
);
  gen_ctrl_t [NUM_GEN-1:0] ctrl_q;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[g] <= '0;
      end else if (wr_en && (int'(wr_sel) == g)) begin
        ctrl_q[g] <= unpack_ctrl(wr_data);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (int'(rd_sel) < NUM_GEN) begin
      rd_data <= pack_ctrl(ctrl_q[rd_sel]);
    end else begin
      rd_data <= '0;
    end
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int RATIO = 16,
  localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic pre_on,
  output logic step
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(RATIO - 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q <= TOP;
    end else if (pre_on) begin
      cnt_q <= (cnt_q == '0) ? TOP : cnt_q - 1'b1;
    end else begin
      cnt_q <= TOP;
    end
  end

  assign step = active && (!pre_on || (cnt_q == '0));
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             step,
  output logic             running,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      running <= 1'b0;
      tick    <= 1'b0;
    end else if (!en) begin
      cnt_q   <= div;
      running <= 1'b0;
      tick    <= 1'b0;
    end else if (!running) begin
      cnt_q   <= div;
      running <= 1'b1;
      tick    <= 1'b0;
    end else if (step) begin
      if (cnt_q == '0) begin
        cnt_q <= div;
        tick  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        tick  <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_gen_unit.sv
module baud_gen_unit
  import baud_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  gen_ctrl_t ctrl,
  output logic      tick
);
  logic running;
  logic step;

  baud_prescale #(.RATIO(PRE_RATIO)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .active (ctrl.en && running),
    .pre_on (ctrl.pre),
    .step   (step)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .en      (ctrl.en),
    .div     (ctrl.div),
    .step    (step),
    .running (running),
    .tick    (tick)
  );
endmodule

// File: rtl/baud_gen_bank.sv
module baud_gen_bank
  import baud_pkg::*;
#(
  parameter int NUM_GEN = 4,
  localparam int SEL_W = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [CTRL_W-1:0]  wr_data,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [CTRL_W-1:0]  rd_data,
  output logic [NUM_GEN-1:0] tick
);
  gen_ctrl_t [NUM_GEN-1:0] ctrl;
  logic [NUM_GEN-1:0]      gen_en;
  logic [NUM_GEN-1:0]      gen_pre;

  baud_ctrl_regs #(.NUM_GEN(NUM_GEN)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .ctrl    (ctrl)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    assign gen_en[g]  = ctrl[g].en;
    assign gen_pre[g] = ctrl[g].pre;
    baud_gen_unit u_unit (
      .clk  (clk),
      .rst  (rst),
      .ctrl (ctrl[g]),
      .tick (tick[g])
    );
  end
endmodule

// File: rtl/baud_gen_bank_chk.sv
module baud_gen_bank_chk
  import baud_pkg::*;
#(
  parameter int NUM_GEN = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [CTRL_W-1:0]  rd_data,
  input logic [NUM_GEN-1:0] tick,
  input logic [NUM_GEN-1:0] gen_en,
  input logic [NUM_GEN-1:0] gen_pre
);
  localparam logic [CTRL_W-1:0] LIVE_MASK =
    (CTRL_W'(1) << EN_BIT) | (CTRL_W'(1) << PRE_BIT) |
    (((CTRL_W'(1) << DIV_W) - 1) << DIV_LSB);

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (tick == '0 && rd_data == '0)); // R1

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~LIVE_MASK) == '0); // R2

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
      !gen_en[g] |=> !tick[g]); // R7

    AST_START_QUIET: assert property (@(posedge clk) disable iff (rst)
      $rose(gen_en[g]) |=> !tick[g]); // R3

    AST_PRE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      (tick[g] && gen_pre[g]) |=> !tick[g]); // R6
  end
endmodule

bind baud_gen_bank baud_gen_bank_chk #(.NUM_GEN(NUM_GEN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_data (rd_data),
  .tick    (tick),
  .gen_en  (gen_en),
  .gen_pre (gen_pre)
);

// File: tb/test_baud_gen_bank.sv
module test_baud_gen_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic [NG-1:0] tick;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  baud_gen_bank #(.NUM_GEN(NG)) i_baud_gen_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .tick(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] word(input bit en, input bit pre, input int n);
    return (32'(en) << 16) | (32'(n & 12'hFFF) << 1) | 32'(pre);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input int idx, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = 2'(idx); wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_ctrl(input int idx, output logic [31:0] d);
    rd_sel = 2'(idx);
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_tick(input int g, input int limit, output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk);
      n++;
    end while (!tick[g] && n < limit);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(tick == '0, "R1 tick", tick, 0);
    for (int i = 0; i < NG; i++) begin
      read_ctrl(i, d);
      check(d == 32'h0, "R1 ctrl", d, 0);
    end
  endtask

  task automatic t_layout;
    logic [31:0] d;
    write_ctrl(1, 32'hFFFF_FFFF);
    read_ctrl(1, d);
    check(d == 32'h0001_1FFF, "R2 readback mask", d, 32'h0001_1FFF);
    write_ctrl(1, word(1'b0, 1'b0, 37));
    read_ctrl(1, d);
    check(d == 32'h0000_004A, "R2 divisor field", d, 32'h4A);
  endtask

  task automatic t_basic;
    int n;
    write_ctrl(0, word(1'b1, 1'b0, 5));
    wait_tick(0, 100, n);
    check(n == 7, "R3 first tick", n, 7);
    wait_tick(0, 100, n);
    check(n == 6, "R4 period N=5", n, 6);
    @(posedge clk); @(negedge clk);
    check(tick[0] == 1'b0, "R6 single pulse", tick[0], 0);
    wait_tick(0, 100, n);
    check(n == 5, "R4 period N=5 after gap", n, 5);
  endtask

  task automatic t_stop_restart;
    int n;
    logic [31:0] d;
    bit seen = 1'b0;
    write_ctrl(0, word(1'b0, 1'b0, 5));
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); @(negedge clk);
      if (tick[0]) seen = 1'b1;
    end
    check(!seen, "R7 no tick while disabled", seen, 0);
    read_ctrl(0, d);
    check(d[16] == 1'b0, "R7 enable cleared", d[16], 0);
    write_ctrl(0, word(1'b1, 1'b0, 3));
    wait_tick(0, 100, n);
    check(n == 5, "R7 restart latency", n, 5);
  endtask

  task automatic t_retune;
    int n;
    write_ctrl(0, word(1'b1, 1'b0, 9));
    wait_tick(0, 100, n);
    repeat (3) begin @(posedge clk); @(negedge clk); end
    write_ctrl(0, word(1'b1, 1'b0, 4));
    wait_tick(0, 100, n);
    check(n == 6, "R8 period in progress kept", n + 4, 10);
    wait_tick(0, 100, n);
    check(n == 5, "R8 new period", n, 5);
    write_ctrl(0, 32'h0);
  endtask

  task automatic t_prescale;
    int n;
    write_ctrl(2, word(1'b1, 1'b1, 2));
    wait_tick(2, 200, n);
    check(n == 49, "R5 prescaled first tick", n, 49);
    wait_tick(2, 200, n);
    check(n == 48, "R5 prescaled period", n, 48);
    write_ctrl(2, 32'h0);
  endtask

  task automatic t_zero_div;
    int n;
    write_ctrl(1, word(1'b1, 1'b0, 0));
    wait_tick(1, 20, n);
    check(n == 2, "R4 N=0 first tick", n, 2);
    wait_tick(1, 20, n);
    check(n == 1, "R4 N=0 continuous", n, 1);
    write_ctrl(1, 32'h0);
  endtask

  task automatic t_independent;
    int n;
    write_ctrl(2, word(1'b1, 1'b0, 5));
    write_ctrl(3, word(1'b1, 1'b0, 7));
    wait_tick(3, 100, n);
    check(n == 9, "R9 second gen latency", n, 9);
    wait_tick(3, 100, n);
    check(n == 8, "R9 second gen period", n, 8);
    wait_tick(2, 100, n);
    wait_tick(2, 100, n);
    check(n == 6, "R9 first gen period", n, 6);
    write_ctrl(2, 32'h0);
    write_ctrl(3, 32'h0);
  endtask

  task automatic t_max_div;
    int n;
    write_ctrl(0, word(1'b1, 1'b0, 4095));
    wait_tick(0, 5000, n);
    check(n == 4097, "R10 max first tick", n, 4097);
    wait_tick(0, 5000, n);
    check(n == 4096, "R10 max period", n, 4096);
    write_ctrl(0, 32'h0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_layout();
    t_basic();
    t_stop_restart();
    t_retune();
    t_prescale();
    t_zero_div();
    t_independent();
    t_max_div();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule